// File: doc/BRIEF.md
# Radio Frame FIFO Pair with Threshold Flag

This block sits between a host-side byte port and a radio-side byte port. Bytes flow through two 128-byte queues. The receive queue is filled by the radio and drained by the host. The transmit queue is filled by the host and drained by the radio. Every frame in either queue begins with a length byte. That byte counts the bytes that follow it plus a two-byte checksum.

On the receive side the block keeps track of frame boundaries on both the write and the read pointer. It raises a frame-pending flag when the stored byte count reaches a programmable threshold. It also raises the flag as soon as one complete frame is present. A second pin shows that the queue holds data. An overflow is shown by a particular pin combination: the pending flag high while the data pin is low. On the transmit side the block follows the frame the radio is draining. The checksum is produced further on in the radio path, so the radio reads the length byte and then length minus two bytes. If the radio reads from an empty queue before the frame is finished, an underflow is flagged in the status byte. Each queue has its own single-cycle flush.

Top module: `radio_frame_fifo`

## Requirements
- R1: After reset, `fifo_pin`, `fifop` and `status` are all 0, and the threshold is 127.
- R2: `fifo_pin` is 1 exactly when the receive queue holds at least one byte and no overflow is pending. `host_rx_data` shows the oldest byte, and bytes come out in the order they were written.
- R3: `fifop` is 1 while the stored receive byte count is greater than or equal to the threshold. A one-cycle `thr_wr` loads the threshold from `thr_val`.
- R4: A length byte L with 2 <= L <= 127, followed by L further bytes, forms a complete frame. `fifop` is 1 while any complete frame remains unread. Once the last byte of such a frame has been read, and the count is below the threshold, `fifop` returns to 0.
- R5: A length byte below 2 or above 127 sets status bit 1. That byte counts as a complete frame on its own.
- R6: A write into a full (128-byte) receive queue sets status bit 0. It also drives `fifop` to 1 and `fifo_pin` to 0. From then on every radio write is discarded until a receive flush, but host reads still work.
- R7: `flush_rx` empties the receive queue and clears status bits 1 and 0 in one cycle. It wins over a radio write in the same cycle.
- R8: The radio reads the transmit queue in write order: a length byte L, then L-2 bytes.
- R9: A radio read of the empty transmit queue while bytes of the current frame are still owed sets status bit 3. The same read between frames does not set it.
- R10: `flush_tx` empties the transmit queue and clears status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rad_rx_wr | input | 1 | Radio pushes a received byte |
| rad_rx_data | input | 8 | Received byte |
| host_rx_rd | input | 1 | Host pops the oldest received byte |
| host_rx_data | output | 8 | Oldest received byte (show-ahead) |
| host_tx_wr | input | 1 | Host pushes a byte to transmit |
| host_tx_data | input | 8 | Byte to transmit |
| rad_tx_rd | input | 1 | Radio pops the oldest transmit byte |
| rad_tx_data | output | 8 | Oldest transmit byte (show-ahead) |
| flush_rx | input | 1 | Empty the receive queue and clear its flags |
| flush_tx | input | 1 | Empty the transmit queue and clear underflow |
| thr_wr | input | 1 | Load a new threshold |
| thr_val | input | 7 | Threshold value |
| fifo_pin | output | 1 | Receive data present |
| fifop | output | 1 | Threshold reached, frame complete, or overflow |
| status | output | 8 | Bit 3 TX underflow, bit 1 bad length, bit 0 RX overflow, rest 0 |

## Verification
A vector table pairs threshold settings with frames that are cut off at chosen byte counts. The cases cover a finished frame below the threshold, an unfinished frame that has reached the threshold, and the same frame one byte short of it. Together these separate the byte-count path from the frame-complete path of the pending flag. The lengths 0, 1, 2, 127 and 200 mark the edges of the valid length range.

Directed sequences then cover the following:
- Reading a frame out, to confirm that the flag drops only after the last byte.
- Filling the queue to 128 bytes and pushing one more, which shows the overflow pin pairing. A write attempted during the overflow must not land in memory.
- A flush that coincides with a write.
- A transmit read that runs dry mid-frame, compared with one that runs dry between frames.

// File: rtl/radio_frame_fifo.sv
module radio_frame_fifo #(
  parameter int DEPTH     = 128,
  parameter int MAXLEN    = 127,
  parameter int THR_RESET = 127,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rad_rx_wr,
  input  logic [7:0]    rad_rx_data,
  input  logic          host_rx_rd,
  output logic [7:0]    host_rx_data,
  input  logic          host_tx_wr,
  input  logic [7:0]    host_tx_data,
  input  logic          rad_tx_rd,
  output logic [7:0]    rad_tx_data,
  input  logic          flush_rx,
  input  logic          flush_tx,
  input  logic          thr_wr,
  input  logic [AW-1:0] thr_val,
  output logic          fifo_pin,
  output logic          fifop,
  output logic [7:0]    status
);

  function automatic logic len_ok(input logic [7:0] l);
    return (l >= 8'd2) && (l <= 8'(MAXLEN));
  endfunction

  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt, rx_frames;
  logic [7:0]    rx_wrem, rx_rrem;
  logic          rx_ovf, rx_bad;
  logic [AW-1:0] thr;

  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    tx_rrem;
  logic          tx_unf;

  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;

  wire rx_we = rad_rx_wr & ~rx_full & ~rx_ovf & ~flush_rx;
  wire rx_re = host_rx_rd & ~rx_empty & ~flush_rx;
  wire tx_we = host_tx_wr & ~tx_full & ~flush_tx;
  wire tx_re = rad_tx_rd & ~tx_empty & ~flush_tx;

  assign host_rx_data = rx_mem[rx_rp];
  assign rad_tx_data  = tx_mem[tx_rp];

  wire rx_wdone = rx_we & ((rx_wrem == 8'd0) ? !len_ok(rad_rx_data) : (rx_wrem == 8'd1));
  wire rx_rdone = rx_re & ((rx_rrem == 8'd0) ? !len_ok(host_rx_data) : (rx_rrem == 8'd1));

  assign fifo_pin = ~rx_empty & ~rx_ovf;
  assign fifop    = rx_ovf | (rx_cnt >= CW'(thr)) | (rx_frames != '0);
  assign status   = {4'b0000, tx_unf, 1'b0, rx_bad, rx_ovf};

  always_ff @(posedge clk) begin
    if (rx_we) rx_mem[rx_wp] <= rad_rx_data;
    if (tx_we) tx_mem[tx_wp] <= host_tx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) thr <= AW'(THR_RESET);
    else if (thr_wr) thr <= thr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_rx) begin
      rx_wp     <= '0;
      rx_rp     <= '0;
      rx_cnt    <= '0;
      rx_frames <= '0;
      rx_wrem   <= '0;
      rx_rrem   <= '0;
      rx_ovf    <= 1'b0;
      rx_bad    <= 1'b0;
    end else begin
      if (rad_rx_wr && rx_full) rx_ovf <= 1'b1;
      if (rx_we) begin
        rx_wp <= rx_wp + 1'b1;
        if (rx_wrem == 8'd0) begin
          rx_wrem <= len_ok(rad_rx_data) ? rad_rx_data : 8'd0;
          if (!len_ok(rad_rx_data)) rx_bad <= 1'b1;
        end else begin
          rx_wrem <= rx_wrem - 8'd1;
        end
      end
      if (rx_re) begin
        rx_rp <= rx_rp + 1'b1;
        if (rx_rrem == 8'd0) rx_rrem <= len_ok(host_rx_data) ? host_rx_data : 8'd0;
        else                 rx_rrem <= rx_rrem - 8'd1;
      end
      rx_cnt    <= rx_cnt + CW'(rx_we) - CW'(rx_re);
      rx_frames <= rx_frames + CW'(rx_wdone) - CW'(rx_rdone);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_tx) begin
      tx_wp   <= '0;
      tx_rp   <= '0;
      tx_cnt  <= '0;
      tx_rrem <= '0;
      tx_unf  <= 1'b0;
    end else begin
      if (rad_tx_rd && tx_empty && tx_rrem != 8'd0) tx_unf <= 1'b1;
      if (tx_we) tx_wp <= tx_wp + 1'b1;
      if (tx_re) begin
        tx_rp <= tx_rp + 1'b1;
        if (tx_rrem == 8'd0) tx_rrem <= (rad_tx_data >= 8'd2) ? rad_tx_data - 8'd2 : 8'd0;
        else                 tx_rrem <= tx_rrem - 8'd1;
      end
      tx_cnt <= tx_cnt + CW'(tx_we) - CW'(tx_re);
    end
  end

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx |=> !fifo_pin && status[1:0] == 2'b00 && rx_cnt == '0);

  a_r6_ovf_pins: assert property (@(posedge clk) disable iff (!rst_n)
    rad_rx_wr && rx_full && !flush_rx |=> fifop && !fifo_pin && status[0]);

  a_r6_ovf_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf && !flush_rx && !host_rx_rd |=> $stable(rx_cnt));

  a_r4_frames_fit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frames <= rx_cnt);

  a_r2_pin_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_pin) |-> $past(rad_rx_wr));

  a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rad_tx_rd && tx_empty && tx_rrem != 8'd0 && !flush_tx |=> status[3]);

  a_r10_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx |=> !status[3] && tx_cnt == '0);

endmodule

// File: tb/sim_radio_frame_fifo.sv
module sim_radio_frame_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rad_rx_wr = 1'b0, host_rx_rd = 1'b0, host_tx_wr = 1'b0, rad_tx_rd = 1'b0;
  logic flush_rx = 1'b0, flush_tx = 1'b0, thr_wr = 1'b0;
  logic [7:0] rad_rx_data = 8'h00, host_tx_data = 8'h00;
  logic [6:0] thr_val = 7'd0;
  logic [7:0] host_rx_data, rad_tx_data, status;
  logic fifo_pin, fifop;
  int applied = 0, bad = 0;

  always #4 clk = ~clk;

  radio_frame_fifo u0 (
    .clk(clk), .rst_n(rst_n),
    .rad_rx_wr(rad_rx_wr), .rad_rx_data(rad_rx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .rad_tx_rd(rad_tx_rd), .rad_tx_data(rad_tx_data),
    .flush_rx(flush_rx), .flush_tx(flush_tx),
    .thr_wr(thr_wr), .thr_val(thr_val),
    .fifo_pin(fifo_pin), .fifop(fifop), .status(status)
  );

  // {threshold, length byte, bytes after it, expected {fifop, fifo_pin, status[1]}}
  localparam logic [31:0] VEC [11] = '{
    32'h7F050506, 32'h7F050402, 32'h040A0306, 32'h050A0302,
    32'h7F010007, 32'h7FC80007, 32'h7F020206, 32'h7F7F7E06,
    32'h7F7F7D02, 32'h00090006, 32'h7F000007
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_rx(input logic [7:0] b);
    rad_rx_wr = 1'b1; rad_rx_data = b;
    @(negedge clk);
    rad_rx_wr = 1'b0;
  endtask

  task automatic rd_rx();
    host_rx_rd = 1'b1;
    @(negedge clk);
    host_rx_rd = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] b);
    host_tx_wr = 1'b1; host_tx_data = b;
    @(negedge clk);
    host_tx_wr = 1'b0;
  endtask

  task automatic rd_tx();
    rad_tx_rd = 1'b1;
    @(negedge clk);
    rad_tx_rd = 1'b0;
  endtask

  task automatic pulse_flush_rx();
    flush_rx = 1'b1;
    @(negedge clk);
    flush_rx = 1'b0;
  endtask

  task automatic set_thr(input logic [6:0] t);
    thr_wr = 1'b1; thr_val = t;
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    int errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({6'd0, fifop, fifo_pin}, 8'h00, "R1 pins");
    chk(status, 8'h00, "R1 status");

    // R1/R3: default threshold of 127
    wr_rx(8'h7F);
    for (int k = 1; k <= 125; k++) wr_rx(8'(k));
    chk({7'd0, fifop}, 8'h00, "R3 default thr, 126 bytes");
    wr_rx(8'h7E);
    chk({7'd0, fifop}, 8'h01, "R1 default thr, 127 bytes");

    // Vector table: R3 threshold, R4 frame complete, R5 bad length
    foreach (VEC[i]) begin
      pulse_flush_rx();
      set_thr(VEC[i][30:24]);
      wr_rx(VEC[i][23:16]);
      for (int k = 0; k < int'(VEC[i][15:8]); k++) wr_rx(8'h40 + 8'(k));
      chk({5'd0, fifop, fifo_pin, status[1]}, VEC[i][7:0], "R3/R4/R5 vector");
    end

    // R2/R4: read a frame out in order
    pulse_flush_rx();
    set_thr(7'd127);
    chk({7'd0, fifo_pin}, 8'h00, "R2 empty after flush");
    wr_rx(8'h03); wr_rx(8'h11); wr_rx(8'h22); wr_rx(8'h33);
    chk({6'd0, fifop, fifo_pin}, 8'h03, "R4 frame stored");
    chk(host_rx_data, 8'h03, "R2 order 0"); rd_rx();
    chk(host_rx_data, 8'h11, "R2 order 1"); rd_rx();
    chk({7'd0, fifop}, 8'h01, "R4 partly read frame keeps flag");
    chk(host_rx_data, 8'h22, "R2 order 2"); rd_rx();
    chk(host_rx_data, 8'h33, "R2 order 3"); rd_rx();
    chk({6'd0, fifop, fifo_pin}, 8'h00, "R4 flag drops after last byte");

    // R6 overflow
    pulse_flush_rx();
    wr_rx(8'h7F);
    for (int k = 1; k <= 127; k++) wr_rx(8'(k));
    chk({5'd0, fifop, fifo_pin, status[0]}, 8'h06, "R6 full, no overflow yet");
    wr_rx(8'hEE);
    chk({5'd0, fifop, fifo_pin, status[0]}, 8'h05, "R6 overflow pins");
    chk(host_rx_data, 8'h7F, "R6 read during overflow");
    rd_rx();
    wr_rx(8'hEE);
    errs = 0;
    for (int k = 1; k <= 127; k++) begin
      if (host_rx_data !== 8'(k)) errs++;
      rd_rx();
    end
    chk(8'(errs), 8'h00, "R6 stored bytes intact");
    chk(host_rx_data, 8'h7F, "R6 write during overflow discarded");

    // R7 flush wins over simultaneous write
    flush_rx = 1'b1; rad_rx_wr = 1'b1; rad_rx_data = 8'h33;
    @(negedge clk);
    flush_rx = 1'b0; rad_rx_wr = 1'b0;
    chk({5'd0, fifop, fifo_pin, 1'b0}, 8'h00, "R7 flush with write pins");
    chk(status, 8'h00, "R7 flush clears status");

    // R8 transmit order
    wr_tx(8'h04); wr_tx(8'hA1); wr_tx(8'hA2);
    chk(rad_tx_data, 8'h04, "R8 tx length"); rd_tx();
    chk(rad_tx_data, 8'hA1, "R8 tx byte 1"); rd_tx();
    chk(rad_tx_data, 8'hA2, "R8 tx byte 2"); rd_tx();
    rd_tx();
    chk(status, 8'h00, "R9 empty read between frames");

    // R9 underflow mid-frame, R10 flush
    wr_tx(8'h05); wr_tx(8'hB1);
    rd_tx(); rd_tx();
    chk(status, 8'h00, "R9 no underflow yet");
    rd_tx();
    chk(status, 8'h08, "R9 underflow mid-frame");
    flush_tx = 1'b1;
    @(negedge clk);
    flush_tx = 1'b0;
    chk(status, 8'h00, "R10 tx flush clears underflow");
    wr_tx(8'h02);
    chk(rad_tx_data, 8'h02, "R10 tx queue restarts empty");

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule